// File: doc/BRIEF.md
# Microcontroller Bus Glue

This block sits between an 8-bit microcontroller and a 32 KB static RAM. The microcontroller puts the low byte of each address and then the data byte on one shared port (P0), and the high address byte on a second port (P2). The glue holds the low address byte while the address-latch strobe (ALE) is high and keeps it once ALE falls. It combines that byte with the lower seven bits of the high byte to form the RAM address. It decodes the high byte with the program-fetch strobe and the read and write strobes into active-low RAM chip-select and output-enable. One code-and-data RAM thus serves every fetch and every data access.

The top 256-byte page of the address space (high byte 0xFF) is a display page. The RAM is never selected there. A write to that page loads an eight-bit latch that drives a seven-segment LED digit. The glue also owns the processor's reset pin and the clock sent to its crystal input. It passes the host parallel-port data byte straight through to processor port pins.

A small controller state machine runs the processor. ST_BOOT holds reset high for BOOT_CYC clocks while the processor clock runs. The BOOT_DONE transition then moves to ST_RUN. From ST_RUN, HOLD_ENTER (hold request) moves to ST_HALT and PAUSE_ENTER (pause request, with hold taking priority) moves to ST_FREEZE. From ST_FREEZE, HOLD_ENTER moves to ST_HALT and PAUSE_LEAVE (pause released) moves back to ST_RUN. From ST_HALT, HOLD_LEAVE moves to ST_BOOT, which begins a fresh reset pulse. While reset is high, chip-select and output-enable are forced high so the RAM stays off the bus. The processor clock is the system clock divided by two. It is frozen in ST_FREEZE.

Top module: `mcu_bus_glue`

## Requirements
- R1: The RAM address low byte equals P0 in the same cycle while ALE is high. It keeps the last value present at a clock edge with ALE high once ALE is low. It is 0x00 after reset.
- R2: RAM address bits 14:8 equal P2 bits 6:0 in the same cycle.
- R3: RAM output-enable (active low) is 0 exactly when (program-fetch strobe is 0 or read strobe is 0), P2 is not 0xFF and the controller is in ST_RUN or ST_FREEZE. It is 1 otherwise, so a write alone never drives it low.
- R4: RAM chip-select (active low) is 0 exactly when (program-fetch, read or write strobe is 0), P2 is not 0xFF and the controller is in ST_RUN or ST_FREEZE. It is 1 otherwise.
- R5: With P2 equal to 0xFF, chip-select and output-enable are both 1 for every strobe combination.
- R6: The display output loads the P0 value sampled in the last cycle the write strobe was low, at the edge where the write strobe is first seen high again. It loads only if P2 was 0xFF in that low cycle. Any other write leaves it unchanged, and it is 0x00 after reset.
- R7: After reset is released, the processor reset output stays 1 for exactly BOOT_CYC clock edges (BOOT_DONE) and is 0 afterwards.
- R8: A hold request seen at a clock edge drives the processor reset output to 1 after that edge (HOLD_ENTER), taking priority over a pause request. After release, reset stays 1 for BOOT_CYC+1 further edges (HOLD_LEAVE, then BOOT_DONE).
- R9: The processor clock output toggles at every clock edge that finds the controller outside ST_FREEZE. It keeps its level in ST_FREEZE, which a pause request enters from ST_RUN (PAUSE_ENTER) and whose release leaves it (PAUSE_LEAVE).
- R10: The host data byte appears unchanged on the processor-side host output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock from the oscillator |
| rst_ni | input | 1 | Active-low reset of the glue |
| ale_i | input | 1 | Address-latch strobe from the processor |
| psen_ni | input | 1 | Program-fetch strobe, active low |
| rd_ni | input | 1 | Data read strobe, active low |
| wr_ni | input | 1 | Data write strobe, active low |
| p0_i | input | 8 | Multiplexed low address / data port |
| p2_i | input | 8 | High address byte |
| hold_req_i | input | 1 | Request to hold the processor in reset |
| pause_req_i | input | 1 | Request to stop the processor clock |
| host_data_i | input | 8 | Host parallel-port data byte |
| ram_addr_o | output | 15 | RAM address |
| ram_cs_no | output | 1 | RAM chip-select, active low |
| ram_oe_no | output | 1 | RAM output-enable, active low |
| mcu_rst_o | output | 1 | Processor reset, active high |
| mcu_xtal_o | output | 1 | Clock to the processor crystal input |
| mcu_host_o | output | 8 | Host data byte passed to processor pins |
| disp_o | output | 8 | LED digit segment latch |

## Verification
The address, chip-select, output-enable and host pass-through results are combinational. The bench drives them one time unit after a clock edge and checks them one more unit later, without an edge in between. The display latch, the processor reset and the processor clock each change at the first edge after their cause. The bench therefore steps exactly one edge and samples one unit after it. For the boot pulse it counts edges from the release of reset or of the hold request and checks both the last high edge and the first low edge. The decoder is swept over all 256 high-byte values and all eight strobe combinations, both with the processor running and held in reset. The latch is swept over all 256 byte values.

// File: rtl/glue_pkg.sv
package glue_pkg;
    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_RUN    = 2'd1,
        ST_HALT   = 2'd2,
        ST_FREEZE = 2'd3
    } ctrl_state_e;
endpackage

// File: rtl/glue_addr_latch.sv
module glue_addr_latch #(
    parameter int LO_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ale_i,
    input  logic [LO_W-1:0] p0_i,
    output logic [LO_W-1:0] addr_lo_o
);
    logic [LO_W-1:0] held_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            held_q <= '0;
        end else if (ale_i) begin
            held_q <= p0_i;
        end
    end

    // transparent while the strobe is high, held once it drops
    assign addr_lo_o = ale_i ? p0_i : held_q;

    assert_hold_after_ale_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ale_i) |=> (!ale_i) -> $stable(addr_lo_o));
endmodule

// File: rtl/glue_mem_decode.sv
module glue_mem_decode #(
    parameter int          HI_W      = 8,
    parameter logic [7:0]  DISP_PAGE = 8'hFF
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [HI_W-1:0] hi_i,
    input  logic            psen_ni,
    input  logic            rd_ni,
    input  logic            wr_ni,
    input  logic            bus_en_i,
    output logic            in_disp_o,
    output logic            cs_no,
    output logic            oe_no
);
    logic read_cyc;
    logic any_cyc;
    logic ram_hit;

    always_comb begin
        in_disp_o = (hi_i == HI_W'(DISP_PAGE));
        read_cyc  = !psen_ni || !rd_ni;
        any_cyc   = read_cyc || !wr_ni;
        ram_hit   = !in_disp_o && bus_en_i;
        oe_no     = !(read_cyc && ram_hit);
        cs_no     = !(any_cyc && ram_hit);
    end

    assert_disp_page_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hi_i == HI_W'(DISP_PAGE)) |-> (cs_no && oe_no));

    assert_oe_needs_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!oe_no) |-> (!cs_no));

    assert_write_no_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (psen_ni && rd_ni) |-> oe_no);
endmodule

// File: rtl/glue_disp_latch.sv
module glue_disp_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_ni,
    input  logic              in_disp_i,
    input  logic [DATA_W-1:0] p0_i,
    output logic [DATA_W-1:0] disp_o
);
    logic              wr_n_q;
    logic              sel_q;
    logic [DATA_W-1:0] data_q;
    logic              wr_rise;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_n_q <= 1'b1;
            sel_q  <= 1'b0;
            data_q <= '0;
        end else begin
            wr_n_q <= wr_ni;
            if (!wr_ni) begin
                sel_q  <= in_disp_i;
                data_q <= p0_i;
            end
        end
    end

    assign wr_rise = !wr_n_q && wr_ni;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            disp_o <= '0;
        end else if (wr_rise && sel_q) begin
            disp_o <= data_q;
        end
    end

    assert_disp_only_on_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_n_q || !wr_ni) |=> $stable(disp_o));
endmodule

// File: rtl/glue_mcu_ctrl.sv
module glue_mcu_ctrl
    import glue_pkg::*;
#(
    parameter int BOOT_CYC = 16
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        hold_req_i,
    input  logic        pause_req_i,
    output ctrl_state_e state_o,
    output logic        mcu_rst_o,
    output logic        bus_en_o,
    output logic        xtal_o
);
    localparam int CNT_W = $clog2(BOOT_CYC + 1);

    ctrl_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             xtal_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   if (cnt_q == CNT_W'(BOOT_CYC - 1)) state_d = ST_RUN;
            ST_RUN:    if (hold_req_i) state_d = ST_HALT;
                       else if (pause_req_i) state_d = ST_FREEZE;
            ST_FREEZE: if (hold_req_i) state_d = ST_HALT;
                       else if (!pause_req_i) state_d = ST_RUN;
            ST_HALT:   if (!hold_req_i) state_d = ST_BOOT;
        endcase
    end

    // state register with boot counter and clock divider
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_BOOT;
            cnt_q   <= '0;
            xtal_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_BOOT && state_d == ST_BOOT) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
            if (state_q != ST_FREEZE) begin
                xtal_q <= !xtal_q;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_BOOT:   begin mcu_rst_o = 1'b1; bus_en_o = 1'b0; end
            ST_RUN:    begin mcu_rst_o = 1'b0; bus_en_o = 1'b1; end
            ST_FREEZE: begin mcu_rst_o = 1'b0; bus_en_o = 1'b1; end
            ST_HALT:   begin mcu_rst_o = 1'b1; bus_en_o = 1'b0; end
        endcase
    end

    assign state_o = state_q;
    assign xtal_o  = xtal_q;

    assert_hold_forces_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_req_i |=> mcu_rst_o);

    assert_freeze_keeps_clock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FREEZE) |=> $stable(xtal_o));

    assert_run_toggles_clock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN) |=> (xtal_o != $past(xtal_o)));

    assert_boot_bounded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BOOT) |-> (cnt_q < CNT_W'(BOOT_CYC)));
endmodule

// File: rtl/mcu_bus_glue.sv
module mcu_bus_glue
    import glue_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter int         RAM_AW    = 15,
    parameter int         BOOT_CYC  = 16,
    parameter logic [7:0] DISP_PAGE = 8'hFF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ale_i,
    input  logic              psen_ni,
    input  logic              rd_ni,
    input  logic              wr_ni,
    input  logic [DATA_W-1:0] p0_i,
    input  logic [DATA_W-1:0] p2_i,
    input  logic              hold_req_i,
    input  logic              pause_req_i,
    input  logic [DATA_W-1:0] host_data_i,
    output logic [RAM_AW-1:0] ram_addr_o,
    output logic              ram_cs_no,
    output logic              ram_oe_no,
    output logic              mcu_rst_o,
    output logic              mcu_xtal_o,
    output logic [DATA_W-1:0] mcu_host_o,
    output logic [DATA_W-1:0] disp_o
);
    localparam int HI_RAM_W = RAM_AW - DATA_W;

    logic [DATA_W-1:0] addr_lo;
    logic              in_disp;
    logic              bus_en;
    ctrl_state_e       state;

    glue_addr_latch #(.LO_W(DATA_W)) u_addr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ale_i     (ale_i),
        .p0_i      (p0_i),
        .addr_lo_o (addr_lo)
    );

    glue_mem_decode #(.HI_W(DATA_W), .DISP_PAGE(DISP_PAGE)) u_dec (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hi_i      (p2_i),
        .psen_ni   (psen_ni),
        .rd_ni     (rd_ni),
        .wr_ni     (wr_ni),
        .bus_en_i  (bus_en),
        .in_disp_o (in_disp),
        .cs_no     (ram_cs_no),
        .oe_no     (ram_oe_no)
    );

    glue_disp_latch #(.DATA_W(DATA_W)) u_disp (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_ni     (wr_ni),
        .in_disp_i (in_disp),
        .p0_i      (p0_i),
        .disp_o    (disp_o)
    );

    glue_mcu_ctrl #(.BOOT_CYC(BOOT_CYC)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .hold_req_i  (hold_req_i),
        .pause_req_i (pause_req_i),
        .state_o     (state),
        .mcu_rst_o   (mcu_rst_o),
        .bus_en_o    (bus_en),
        .xtal_o      (mcu_xtal_o)
    );

    assign ram_addr_o = {p2_i[HI_RAM_W-1:0], addr_lo};
    assign mcu_host_o = host_data_i;

    assert_isolate_in_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mcu_rst_o |-> (ram_cs_no && ram_oe_no));

    assert_state_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_HALT) |-> mcu_rst_o);
endmodule

// File: tb/mcu_bus_glue_tb_top.sv
module mcu_bus_glue_tb_top;
    localparam int BC = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ale, psen_n, rd_n, wr_n, hold, pause;
    logic [7:0] p0, p2, host;
    logic [14:0] ram_addr;
    logic       cs_n, oe_n, mrst, xtal;
    logic [7:0] mhost, disp;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    mcu_bus_glue #(.BOOT_CYC(BC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .psen_ni(psen_n),
        .rd_ni(rd_n), .wr_ni(wr_n), .p0_i(p0), .p2_i(p2),
        .hold_req_i(hold), .pause_req_i(pause), .host_data_i(host),
        .ram_addr_o(ram_addr), .ram_cs_no(cs_n), .ram_oe_no(oe_n),
        .mcu_rst_o(mrst), .mcu_xtal_o(xtal), .mcu_host_o(mhost), .disp_o(disp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic sweep_decode(input bit running);
        for (int h = 0; h < 256; h++) begin
            for (int s = 0; s < 8; s++) begin
                p2     = 8'(h);
                psen_n = s[0];
                rd_n   = s[1];
                wr_n   = s[2];
                #1;
                begin
                    bit rdc, anyc, hit;
                    rdc  = !s[0] || !s[1];
                    anyc = rdc || !s[2];
                    hit  = (h != 255) && running;
                    if (h == 255) begin
                        chk("R5 cs", {31'd0, cs_n}, 32'd1);
                        chk("R5 oe", {31'd0, oe_n}, 32'd1);
                    end else begin
                        chk("R3 oe", {31'd0, oe_n}, {31'd0, !(rdc && hit)});
                        chk("R4 cs", {31'd0, cs_n}, {31'd0, !(anyc && hit)});
                    end
                    chk("R2 addr hi", {25'd0, ram_addr[14:8]}, {25'd0, 7'(h)});
                end
            end
        end
        psen_n = 1; rd_n = 1; wr_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic x0;
        rst_n = 0; ale = 0; psen_n = 1; rd_n = 1; wr_n = 1;
        hold = 0; pause = 0; p0 = 8'h00; p2 = 8'h00; host = 8'h00;
        step(); step();
        // reset state
        chk("R1 reset addr", {24'd0, ram_addr[7:0]}, 32'h0);
        chk("R6 reset disp", {24'd0, disp}, 32'h0);
        chk("R7 reset rst", {31'd0, mrst}, 32'd1);
        chk("R4 reset cs", {31'd0, cs_n}, 32'd1);
        rst_n = 1;
        // R7 boot pulse length
        for (int k = 1; k <= BC + 1; k++) begin
            step();
            chk("R7 boot", {31'd0, mrst}, {31'd0, k < BC});
        end
        // R10 pass-through
        for (int v = 0; v < 256; v += 17) begin
            host = 8'(v); #1;
            chk("R10 host", {24'd0, mhost}, v);
        end
        // R1 latch sweep
        for (int v = 0; v < 256; v++) begin
            ale = 1; p0 = 8'(v); #1;
            chk("R1 transparent", {24'd0, ram_addr[7:0]}, v);
            step();
            ale = 0; p0 = ~8'(v); #1;
            chk("R1 hold", {24'd0, ram_addr[7:0]}, v);
            step();
            chk("R1 hold later", {24'd0, ram_addr[7:0]}, v);
        end
        // decode sweep while running
        sweep_decode(1'b1);
        // R6 display writes
        p2 = 8'hFF; p0 = 8'h5A; wr_n = 0; step();
        chk("R6 no load while low", {24'd0, disp}, 32'h0);
        wr_n = 1; p0 = 8'h00; step();
        chk("R6 load on rise", {24'd0, disp}, 32'h5A);
        p2 = 8'h12; p0 = 8'h33; wr_n = 0; step();
        wr_n = 1; step();
        chk("R6 other page ignored", {24'd0, disp}, 32'h5A);
        p2 = 8'hFF; p0 = 8'hC3; wr_n = 0; step(); step();
        chk("R6 long low", {24'd0, disp}, 32'h5A);
        p0 = 8'h81; step();
        wr_n = 1; p2 = 8'h00; p0 = 8'h11; step();
        chk("R6 last low value", {24'd0, disp}, 32'h81);
        // R9 clock toggling in run
        x0 = xtal; step();
        chk("R9 toggle", {31'd0, xtal}, {31'd0, !x0});
        // R9 freeze
        pause = 1; step();
        x0 = xtal; step();
        chk("R9 frozen", {31'd0, xtal}, {31'd0, x0});
        step();
        chk("R9 frozen 2", {31'd0, xtal}, {31'd0, x0});
        chk("R9 no reset in freeze", {31'd0, mrst}, 32'd0);
        pause = 0; step();
        chk("R9 held at leave edge", {31'd0, xtal}, {31'd0, x0});
        step();
        chk("R9 toggles after leave", {31'd0, xtal}, {31'd0, !x0});
        // R8 hold with pause, priority
        hold = 1; pause = 1; step();
        chk("R8 hold priority", {31'd0, mrst}, 32'd1);
        x0 = xtal; step();
        chk("R9 toggle in halt", {31'd0, xtal}, {31'd0, !x0});
        pause = 0;
        sweep_decode(1'b0);
        hold = 0;
        for (int k = 1; k <= BC + 2; k++) begin
            step();
            chk("R8 restart boot", {31'd0, mrst}, {31'd0, k <= BC});
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule